// File: doc/BRIEF.md
# Comma-Driven Word Lock Tracker

This block decides whether a decoded 8B/10B character stream is word-aligned. Each clock it looks at the flags an upstream decoder raises for the current character: a strobe saying a character is present, a flag saying that character is a comma (K-code), and two error flags, one for an unused code and one for a running-disparity violation. From these it keeps a lock state and drives a word-lock flag plus a write strobe for a downstream rate-matching FIFO.

Lock is gained after a run of clean commas and dropped after a run of errored characters. In the default build that means two clean commas in a row to lock, and four errored characters in a row to unlock. The machine therefore has two acquire stages and four locked stages. Both error kinds count the same. A clean character of any kind that arrives while locked ends the error run.

The character strobe forms a one-way stream. There is no ready signal, because a serial line cannot be stalled. A cycle with the strobe low is a bubble: it is neither counted nor written. The FIFO write strobe is the character strobe qualified by the lock flag, in the same cycle. The downstream FIFO must take every write it is given.

Top module: `ws_word_lock`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, word_sync and fifo_wr are low and the machine sits in its first acquire stage.
- R2: word_sync rises on the clock edge that samples the ACQ_COMMAS-th consecutive clean comma (default 2). A clean comma has chr_vld=1, k_found=1, code_err=0 and disp_err=0.
- R3: While acquiring, any valid character that is not a clean comma sends the machine back to the first acquire stage, so the comma count restarts from zero.
- R4: A code error and a disparity error are one error condition. A comma that carries either error does not count toward lock, and a character with either error set, or both, counts as errored while locked.
- R5: While locked, word_sync falls on the clock edge that samples the LOSS_ERRORS-th consecutive errored valid character (default 4). The machine then restarts acquisition from the first stage. A run one shorter than LOSS_ERRORS keeps lock.
- R6: While locked, one clean valid character, whether comma or data, clears the error run. A later loss then needs a full LOSS_ERRORS new errors.
- R7: Cycles with chr_vld=0 change no state. They neither break nor extend a comma run or an error run.
- R8: fifo_wr is high exactly when chr_vld is high and word_sync is high in the same cycle. The character that completes acquisition is therefore not written, and the errored character that ends lock is written.
- R9: ACQ_COMMAS and LOSS_ERRORS are parameters, each at least 1, and they set the two run lengths above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chr_vld | input | 1 | A decoded character is present this cycle |
| k_found | input | 1 | The character is a comma |
| code_err | input | 1 | The character was an unused code |
| disp_err | input | 1 | The character broke running disparity |
| word_sync | output | 1 | Word lock held |
| fifo_wr | output | 1 | Write strobe to the rate-matching FIFO |

## Verification
The bench builds two copies side by side from the same stimulus. One uses the default run lengths of 2 and 4. The other uses ACQ_COMMAS=3 and LOSS_ERRORS=2. The second copy brings the off-by-one limits within easy reach: a three-comma acquire that a stray data character interrupts, and a loss after only two errors. Directed runs of three and four errors, idle bubbles inside runs, and mixed error kinds are then followed by a long weighted-random stretch. That stretch alternates noisy and clean phases, so both machines lock and unlock many times.

// File: rtl/ws_pkg.sv
package ws_pkg;

  typedef enum logic {
    PH_ACQUIRE = 1'b0,
    PH_LOCKED  = 1'b1
  } phase_e;

  typedef struct packed {
    logic err;
    logic good_comma;
  } char_class_t;

endpackage

// File: rtl/ws_char_class.sv
module ws_char_class
  import ws_pkg::*;
(
  input  logic        k_found,
  input  logic        code_err,
  input  logic        disp_err,
  output char_class_t cls
);

  // R4: both error kinds merge into one condition
  always_comb begin
    cls.err        = code_err | disp_err;
    cls.good_comma = k_found & ~(code_err | disp_err);
  end

endmodule

// File: rtl/ws_lock_fsm.sv
module ws_lock_fsm
  import ws_pkg::*;
#(
  parameter int ACQ_COMMAS  = 2,
  parameter int LOSS_ERRORS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        vld,
  input  char_class_t cls,
  output logic        locked
);

  localparam int MAXN = (ACQ_COMMAS > LOSS_ERRORS) ? ACQ_COMMAS : LOSS_ERRORS;
  localparam int CW   = (MAXN > 2) ? $clog2(MAXN) : 1;
  localparam logic [CW-1:0] ACQ_LAST  = CW'(ACQ_COMMAS - 1);
  localparam logic [CW-1:0] LOSS_LAST = CW'(LOSS_ERRORS - 1);

  phase_e        ph, ph_n;
  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    ph_n  = ph;
    cnt_n = cnt;
    if (vld) begin
      unique case (ph)
        PH_ACQUIRE: begin
          if (cls.good_comma) begin
            if (cnt == ACQ_LAST) begin
              ph_n  = PH_LOCKED;
              cnt_n = '0;
            end else begin
              cnt_n = cnt + CW'(1);
            end
          end else begin
            cnt_n = '0;
          end
        end
        PH_LOCKED: begin
          if (cls.err) begin
            if (cnt == LOSS_LAST) begin
              ph_n  = PH_ACQUIRE;
              cnt_n = '0;
            end else begin
              cnt_n = cnt + CW'(1);
            end
          end else begin
            cnt_n = '0;
          end
        end
        default: begin
          ph_n  = PH_ACQUIRE;
          cnt_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph  <= PH_ACQUIRE;
      cnt <= '0;
    end else begin
      ph  <= ph_n;
      cnt <= cnt_n;
    end
  end

  assign locked = (ph == PH_LOCKED);

  // R2: lock is only gained on a valid clean comma
  p_lock_needs_comma_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(vld) && $past(cls.good_comma));

  // R5: lock is only lost on a valid errored character
  p_loss_needs_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(vld) && $past(cls.err));

  // R7: bubbles hold every piece of state
  p_bubble_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> $stable(ph) && $stable(cnt));

  // R6: a clean character while locked keeps lock and clears the run
  p_clean_clears_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && vld && !cls.err) |=> locked && (cnt == '0));

  // R3: a non-clean-comma while acquiring restarts the count
  p_acq_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && vld && !cls.good_comma) |=> !locked && (cnt == '0));

  // R9: run counter stays inside the run length of its phase
  p_cnt_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    locked ? (cnt <= LOSS_LAST) : (cnt <= ACQ_LAST));

endmodule

// File: rtl/ws_word_lock.sv
module ws_word_lock
  import ws_pkg::*;
#(
  parameter int ACQ_COMMAS  = 2,
  parameter int LOSS_ERRORS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chr_vld,
  input  logic k_found,
  input  logic code_err,
  input  logic disp_err,
  output logic word_sync,
  output logic fifo_wr
);

  char_class_t cls;
  logic        locked;

  ws_char_class u_class (
    .k_found  (k_found),
    .code_err (code_err),
    .disp_err (disp_err),
    .cls      (cls)
  );

  ws_lock_fsm #(
    .ACQ_COMMAS  (ACQ_COMMAS),
    .LOSS_ERRORS (LOSS_ERRORS)
  ) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld    (chr_vld),
    .cls    (cls),
    .locked (locked)
  );

  assign word_sync = locked;
  assign fifo_wr   = chr_vld & locked;

  // R8: the character that completes acquisition is not written
  p_no_wr_on_acquire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_sync) |-> $past(chr_vld) && !$past(fifo_wr));

  // R8: the character that ends lock is still written
  p_wr_on_loss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(word_sync) |-> $past(fifo_wr));

  // R1: nothing is written while reset holds
  always_comb begin
    if (!rst_n) a_reset_quiet_r1: assert (!fifo_wr);
  end

endmodule

// File: tb/ws_word_lock_tb.sv
`timescale 1ns/1ps
module ws_word_lock_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chr_vld = 1'b0, k_found = 1'b0, code_err = 1'b0, disp_err = 1'b0;
  logic sync0, wr0, sync1, wr1;

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 1'b0;

  int m_lock[2];
  int m_cnt[2];
  int acq[2]  = '{2, 3};
  int loss[2] = '{4, 2};

  always #2 clk = ~clk;

  ws_word_lock u_dut (
    .clk(clk), .rst_n(rst_n), .chr_vld(chr_vld), .k_found(k_found),
    .code_err(code_err), .disp_err(disp_err), .word_sync(sync0), .fifo_wr(wr0)
  );

  ws_word_lock #(.ACQ_COMMAS(3), .LOSS_ERRORS(2)) u_dut_alt (
    .clk(clk), .rst_n(rst_n), .chr_vld(chr_vld), .k_found(k_found),
    .code_err(code_err), .disp_err(disp_err), .word_sync(sync1), .fifo_wr(wr1)
  );

  task automatic check(input logic got, input logic exp, input string tag, input string what);
    n_checks++;
    if (got !== exp) begin
      n_errs++;
      $display("FAIL %s %s at %0t: got %b expected %b", tag, what, $time, got, exp);
    end
  endtask

  task automatic compare(input logic v, input string tag);
    check(sync0, logic'(m_lock[0] != 0), tag, "word_sync (2/4)");
    check(wr0,   logic'(v && m_lock[0] != 0), tag, "fifo_wr (2/4)");
    check(sync1, logic'(m_lock[1] != 0), tag, "word_sync (3/2)");
    check(wr1,   logic'(v && m_lock[1] != 0), tag, "fifo_wr (3/2)");
  endtask

  task automatic model_update(input logic v, k, c, d);
    for (int i = 0; i < 2; i++) begin
      if (v) begin
        if (m_lock[i] == 0) begin
          if (k && !(c || d)) begin
            m_cnt[i]++;
            if (m_cnt[i] == acq[i]) begin m_lock[i] = 1; m_cnt[i] = 0; end
          end else m_cnt[i] = 0;
        end else begin
          if (c || d) begin
            m_cnt[i]++;
            if (m_cnt[i] == loss[i]) begin m_lock[i] = 0; m_cnt[i] = 0; end
          end else m_cnt[i] = 0;
        end
      end
    end
  endtask

  task automatic step(input logic v, k, c, d, input string tag);
    @(negedge clk);
    chr_vld = v; k_found = k; code_err = c; disp_err = d;
    #1;
    compare(v, tag);
    @(posedge clk);
    model_update(v, k, c, d);
  endtask

  task automatic comma(input string tag); step(1, 1, 0, 0, tag); endtask
  task automatic data(input string tag);  step(1, 0, 0, 0, tag); endtask
  task automatic cerr(input string tag);  step(1, 0, 1, 0, tag); endtask
  task automatic derr(input string tag);  step(1, 0, 0, 1, tag); endtask
  task automatic idle(input string tag);  step(0, 0, 0, 0, tag); endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_errs++;
    n_checks++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 2; i++) begin m_lock[i] = 0; m_cnt[i] = 0; end
    // R1: reset holds everything quiet even with commas present
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      chr_vld = 1; k_found = 1; code_err = 0; disp_err = 0;
      #1;
      compare(1'b1, "R1");
    end
    @(negedge clk);
    rst_n = 1'b1;
    chr_vld = 0; k_found = 0;
    #1;
    compare(1'b0, "R1");
    @(posedge clk);

    // R2: two clean commas lock the default copy, the third locks the other
    comma("R2"); comma("R2"); comma("R8"); data("R8"); data("R8");
    // R7: bubbles while locked
    idle("R7"); idle("R7"); data("R7");
    // R6: runs of three errors broken by clean characters
    cerr("R6"); derr("R6"); cerr("R6"); data("R6");
    cerr("R6"); cerr("R6"); cerr("R6"); comma("R6"); data("R6");
    // R5: four errors, mixed kinds and both at once, end default lock
    cerr("R5"); derr("R5"); step(1, 0, 1, 1, "R4"); derr("R5"); data("R5"); data("R5");
    // R3: acquisition broken by data, by an error, by an errored comma
    comma("R3"); data("R3"); comma("R3"); cerr("R3"); comma("R3"); step(1, 1, 0, 1, "R4");
    comma("R3"); step(1, 1, 1, 0, "R4"); data("R3");
    // R7: a bubble inside a comma run does not break it
    comma("R7"); idle("R7"); idle("R7"); comma("R7"); idle("R7"); comma("R7"); data("R7");
    // R7: a bubble inside an error run does not break it
    cerr("R7"); idle("R7"); cerr("R7"); idle("R7"); cerr("R7"); idle("R7"); cerr("R7"); data("R7");
    // R9: relock both and walk the shorter loss run of the alternate copy
    comma("R9"); comma("R9"); comma("R9"); derr("R9"); data("R9"); derr("R9"); derr("R9"); data("R9");

    // R8: weighted random phases, noisy and clean
    for (int blk = 0; blk < 80; blk++) begin
      int noisy = (blk % 3 == 0) ? 1 : 0;
      for (int j = 0; j < 50; j++) begin
        logic v, k, c, d;
        v = ($urandom_range(0, 4) != 0);
        k = ($urandom_range(0, 2) != 0);
        c = noisy ? ($urandom_range(0, 1) == 0) : ($urandom_range(0, 30) == 0);
        d = noisy ? ($urandom_range(0, 2) == 0) : ($urandom_range(0, 30) == 0);
        step(v, k, c, d, "R8");
      end
    end
    summary();
  end

endmodule